// File: doc/BRIEF.md
# Configuration Access Router with Programmable Bridge Bus Number

This block sits between a configuration access master and a set of configuration-space functions. It splits each access address into a bus number, a device/function number and a register offset. It then steers the access to one of three targets: a function on the primary bus, a function on the secondary bus that sits behind a bridge, or the bridge's own small configuration space, which lives inside the block. The secondary bus number is not fixed. Software writes it into the bridge's configuration bytes, and until it does so nothing is forwarded behind the bridge.

Every access is a single-cycle strobe. One cycle later the block drives a one-hot function select, together with the offset, the write data and the length. Downstream functions return their read data combinationally while their select is high. One cycle after that, the block registers the selected read word, masks it to the access width and raises `rd_valid`. A read that reaches no function returns all ones. A write that reaches no function is dropped.

Top module: `cfg_router`

## Requirements
- R1: The access address is split as follows. Bits 23:16 are the bus number, bits 15:8 are devfn, and bits 7:0 are the register offset. The device number is devfn[7:3] and the function number is devfn[2:0]. A forwarded access drives select bit index devfn, `fwd_off` = address[7:0], and `fwd_len`/`fwd_wdata` copied from the strobe cycle. All of these appear one cycle after the strobe.
- R2: An access to bus 0 whose device number is below NPRI_DEV, and whose PRI_PRESENT bit is set, asserts only `pri_sel[devfn]` for one cycle. It also asserts `fwd_rd` or `fwd_wr`, depending on the strobe.
- R3: An access whose bus number equals the secondary bus number, while that number is nonzero, is handled like R2 but on `sec_sel`, using NSEC_DEV and SEC_PRESENT. While the secondary bus number is 0, no access ever asserts `sec_sel`.
- R4: An access to an unmatched bus, or to an absent device slot, asserts no select and neither `fwd_rd` nor `fwd_wr`. Such a read returns 0xFFFFFFFF masked to the access width.
- R5: Read data appears with `rd_valid` two cycles after the read strobe. It is masked to the access width: length 1 keeps bits 7:0, length 2 keeps bits 15:0, and any other length keeps all 32 bits. Writes never raise `rd_valid`.
- R6: Devfn BRIDGE_DEVFN on bus 0 is the bridge itself and is never forwarded. A read from it returns its dword at offset[7:2], shifted right by 8×offset[1:0]. The dwords are: 0x00 = {BRG_DEVICE_ID, BRG_VENDOR_ID}, 0x04 = 0x00A00006, 0x08 = 0x06040000, 0x0C = 0x00811000, 0x18 = {16'h0, secondary bus, 8'h00}, 0x1C = 0x00A00000, and all other dwords = 0.
- R7: A bridge write at offset 0x19 loads the secondary bus number from data bits 7:0. A bridge write at offset 0x18 with a length other than 1 loads it from data bits 15:8. All other bridge writes are ignored, and that includes a length-1 write at offset 0x18.
- R8: After reset, all selects, `fwd_rd`, `fwd_wr` and `rd_valid` are low, and the secondary bus number is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 24 | Access address {bus, devfn, offset} |
| cfg_wdata | input | 32 | Write data, right-justified |
| cfg_len | input | 3 | Access length in bytes (1, 2 or 4) |
| cfg_wr | input | 1 | Write strobe, one cycle |
| cfg_rd | input | 1 | Read strobe, one cycle; not asserted together with cfg_wr |
| pri_rdata | input | NPRI_DEV*8*32 | Read word of each primary function, slot i at bits 32i+31:32i |
| sec_rdata | input | NSEC_DEV*8*32 | Read word of each secondary function |
| pri_sel | output | NPRI_DEV*8 | One-hot primary function select |
| sec_sel | output | NSEC_DEV*8 | One-hot secondary function select |
| fwd_off | output | 8 | Register offset of the forwarded access |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_len | output | 3 | Forwarded access length |
| fwd_wr | output | 1 | Forwarded write strobe |
| fwd_rd | output | 1 | Forwarded read strobe |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Masked read data |

## Verification
The bench reads every devfn from 0 to 63 on bus 0, on the secondary bus and on an unassigned bus. This separates the primary hits, the secondary hits, the absent slots (both inside and beyond the slot range) and the bridge slot. A wrong select index or a wrong read-mux index shows up because each downstream word carries its own slot number. The secondary bus number is loaded through each write form, and also through the ignored forms, and after each change the bus that stops matching and the bus that starts matching are both probed. Byte, halfword and word reads of the bridge presets and of misses check the width masking and the in-dword shift.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

  typedef enum logic [1:0] {
    TGT_MISS = 2'd0,
    TGT_PRI  = 2'd1,
    TGT_SEC  = 2'd2,
    TGT_BRG  = 2'd3
  } tgt_e;

  function automatic logic [31:0] len_mask(input logic [2:0] len);
    case (len)
      3'd1:    len_mask = 32'h0000_00FF;
      3'd2:    len_mask = 32'h0000_FFFF;
      default: len_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_router_pkg::*;
#(
  parameter int                  NPRI_DEV     = 4,
  parameter int                  NSEC_DEV     = 2,
  parameter logic [NPRI_DEV-1:0] PRI_PRESENT  = '1,
  parameter logic [NSEC_DEV-1:0] SEC_PRESENT  = '1,
  parameter logic [7:0]          BRIDGE_DEVFN = 8'h18
) (
  input  logic [23:0] addr,
  input  logic [7:0]  sec_bus,
  output tgt_e        tgt,
  output logic [7:0]  devfn,
  output logic [7:0]  off
);
  localparam logic [7:0] PRI_BUS = 8'h00;

  logic [7:0] bus;
  logic [4:0] dev;
  logic       pri_ok, sec_ok;

  always_comb begin
    bus   = addr[23:16];
    devfn = addr[15:8];
    off   = addr[7:0];
    dev   = devfn[7:3];
    pri_ok = 1'b0;
    for (int i = 0; i < NPRI_DEV; i++)
      if (dev == 5'(i) && PRI_PRESENT[i]) pri_ok = 1'b1;
    sec_ok = 1'b0;
    for (int j = 0; j < NSEC_DEV; j++)
      if (dev == 5'(j) && SEC_PRESENT[j]) sec_ok = 1'b1;
    if (bus == PRI_BUS) begin
      if (devfn == BRIDGE_DEVFN) tgt = TGT_BRG;
      else if (pri_ok)           tgt = TGT_PRI;
      else                       tgt = TGT_MISS;
    end else if (sec_bus != 8'h00 && bus == sec_bus) begin
      tgt = sec_ok ? TGT_SEC : TGT_MISS;
    end else begin
      tgt = TGT_MISS;
    end
  end

endmodule

// File: rtl/cfg_bridge_regs.sv
module cfg_bridge_regs #(
  parameter logic [15:0] BRG_VENDOR_ID = 16'hABCD,
  parameter logic [15:0] BRG_DEVICE_ID = 16'h0042
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  off,
  input  logic [15:0] wdata,
  input  logic [2:0]  len,
  output logic [7:0]  sec_bus,
  output logic [31:0] rdata
);
  localparam logic [7:0] OFF_BUSNUM_LO = 8'h18;
  localparam logic [7:0] OFF_BUSNUM_HI = 8'h19;

  logic [31:0] dword;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_bus <= 8'h00;
    end else if (wr_en) begin
      if (off == OFF_BUSNUM_HI)
        sec_bus <= wdata[7:0];
      else if (off == OFF_BUSNUM_LO && len != 3'd1)
        sec_bus <= wdata[15:8];
    end
  end

  always_comb begin
    case (off[7:2])
      6'd0:    dword = {BRG_DEVICE_ID, BRG_VENDOR_ID};
      6'd1:    dword = 32'h00A0_0006;
      6'd2:    dword = 32'h0604_0000;
      6'd3:    dword = 32'h0081_1000;
      6'd6:    dword = {16'h0000, sec_bus, 8'h00};
      6'd7:    dword = 32'h00A0_0000;
      default: dword = 32'h0000_0000;
    endcase
    rdata = dword >> {off[1:0], 3'b000};
  end

endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_router_pkg::*;
#(
  parameter int NPRI_FN = 32,
  parameter int NSEC_FN = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_q,
  input  tgt_e                 tgt_q,
  input  logic [7:0]           devfn_q,
  input  logic [2:0]           len_q,
  input  logic [31:0]          brg_q,
  input  logic [NPRI_FN*32-1:0] pri_rdata,
  input  logic [NSEC_FN*32-1:0] sec_rdata,
  output logic                 rd_valid,
  output logic [31:0]          rd_data
);
  logic [31:0] pri_word, sec_word, word;

  always_comb begin
    pri_word = '0;
    for (int i = 0; i < NPRI_FN; i++)
      if (devfn_q == 8'(i)) pri_word = pri_rdata[i*32 +: 32];
    sec_word = '0;
    for (int j = 0; j < NSEC_FN; j++)
      if (devfn_q == 8'(j)) sec_word = sec_rdata[j*32 +: 32];
    case (tgt_q)
      TGT_PRI: word = pri_word;
      TGT_SEC: word = sec_word;
      TGT_BRG: word = brg_q;
      default: word = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_q;
      if (rd_q) rd_data <= word & len_mask(len_q);
    end
  end

endmodule

// File: rtl/cfg_router.sv
module cfg_router
  import cfg_router_pkg::*;
#(
  parameter int                  NPRI_DEV      = 4,
  parameter int                  NSEC_DEV      = 2,
  parameter logic [NPRI_DEV-1:0] PRI_PRESENT   = 4'b0101,
  parameter logic [NSEC_DEV-1:0] SEC_PRESENT   = 2'b01,
  parameter logic [7:0]          BRIDGE_DEVFN  = 8'h18,
  parameter logic [15:0]         BRG_VENDOR_ID = 16'hABCD,
  parameter logic [15:0]         BRG_DEVICE_ID = 16'h0042,
  localparam int                 NPRI_FN       = NPRI_DEV * 8,
  localparam int                 NSEC_FN       = NSEC_DEV * 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [23:0]           cfg_addr,
  input  logic [31:0]           cfg_wdata,
  input  logic [2:0]            cfg_len,
  input  logic                  cfg_wr,
  input  logic                  cfg_rd,
  input  logic [NPRI_FN*32-1:0] pri_rdata,
  input  logic [NSEC_FN*32-1:0] sec_rdata,
  output logic [NPRI_FN-1:0]    pri_sel,
  output logic [NSEC_FN-1:0]    sec_sel,
  output logic [7:0]            fwd_off,
  output logic [31:0]           fwd_wdata,
  output logic [2:0]            fwd_len,
  output logic                  fwd_wr,
  output logic                  fwd_rd,
  output logic                  rd_valid,
  output logic [31:0]           rd_data
);
  tgt_e        tgt, tgt_q;
  logic [7:0]  devfn, off, devfn_q, sec_bus_q;
  logic [31:0] brg_rdata, brg_q;
  logic        rd_q, fwd_hit;

  cfg_addr_decode #(
    .NPRI_DEV(NPRI_DEV), .NSEC_DEV(NSEC_DEV),
    .PRI_PRESENT(PRI_PRESENT), .SEC_PRESENT(SEC_PRESENT),
    .BRIDGE_DEVFN(BRIDGE_DEVFN)
  ) u_decode (
    .addr(cfg_addr), .sec_bus(sec_bus_q),
    .tgt(tgt), .devfn(devfn), .off(off)
  );

  cfg_bridge_regs #(
    .BRG_VENDOR_ID(BRG_VENDOR_ID), .BRG_DEVICE_ID(BRG_DEVICE_ID)
  ) u_bridge (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr && tgt == TGT_BRG),
    .off(off), .wdata(cfg_wdata[15:0]), .len(cfg_len),
    .sec_bus(sec_bus_q), .rdata(brg_rdata)
  );

  assign fwd_hit = (tgt == TGT_PRI) || (tgt == TGT_SEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_sel   <= '0;
      sec_sel   <= '0;
      fwd_wr    <= 1'b0;
      fwd_rd    <= 1'b0;
      rd_q      <= 1'b0;
      fwd_off   <= '0;
      fwd_wdata <= '0;
      fwd_len   <= '0;
      tgt_q     <= TGT_MISS;
      devfn_q   <= '0;
      brg_q     <= '0;
    end else begin
      for (int i = 0; i < NPRI_FN; i++)
        pri_sel[i] <= (cfg_wr || cfg_rd) && tgt == TGT_PRI && devfn == 8'(i);
      for (int j = 0; j < NSEC_FN; j++)
        sec_sel[j] <= (cfg_wr || cfg_rd) && tgt == TGT_SEC && devfn == 8'(j);
      fwd_wr <= cfg_wr && fwd_hit;
      fwd_rd <= cfg_rd && !cfg_wr && fwd_hit;
      rd_q   <= cfg_rd && !cfg_wr;
      if (cfg_wr || cfg_rd) begin
        fwd_off   <= off;
        fwd_wdata <= cfg_wdata;
        fwd_len   <= cfg_len;
        tgt_q     <= tgt;
        devfn_q   <= devfn;
        brg_q     <= brg_rdata;
      end
    end
  end

  cfg_rd_mux #(
    .NPRI_FN(NPRI_FN), .NSEC_FN(NSEC_FN)
  ) u_rdmux (
    .clk(clk), .rst(rst), .rd_q(rd_q), .tgt_q(tgt_q),
    .devfn_q(devfn_q), .len_q(fwd_len), .brg_q(brg_q),
    .pri_rdata(pri_rdata), .sec_rdata(sec_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

endmodule

// File: rtl/cfg_router_chk.sv
module cfg_router_chk #(
  parameter int NPRI_FN = 32,
  parameter int NSEC_FN = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_wr,
  input logic [NPRI_FN-1:0] pri_sel,
  input logic [NSEC_FN-1:0] sec_sel,
  input logic               fwd_rd,
  input logic               fwd_wr,
  input logic               rd_q,
  input logic               rd_valid,
  input logic [31:0]        rd_data,
  input logic [2:0]         fwd_len,
  input logic [7:0]         sec_bus
);
  // R2 / R3: at most one function selected
  a_r2_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pri_sel, sec_sel}));

  // R4: a select comes only with a forwarded strobe
  a_r4_sel_with_strobe: assert property (@(posedge clk) disable iff (rst)
    (|{pri_sel, sec_sel}) |-> (fwd_rd || fwd_wr));

  // R5: read data valid one cycle after the decoded read
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_q |=> rd_valid);
  a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !rd_q |=> !rd_valid);

  // R5: byte reads carry zeros above bit 7
  a_r5_byte_mask: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(fwd_len) == 3'd1) |-> rd_data[31:8] == 24'h0);

  // R3: no secondary select while the bus number is unassigned
  a_r3_unassigned: assert property (@(posedge clk) disable iff (rst)
    sec_bus == 8'h00 |=> sec_sel == '0);

  // R7: secondary bus number changes only after a write
  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(sec_bus));

endmodule

bind cfg_router cfg_router_chk #(
  .NPRI_FN(NPRI_DEV * 8), .NSEC_FN(NSEC_DEV * 8)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr),
  .pri_sel(pri_sel), .sec_sel(sec_sel),
  .fwd_rd(fwd_rd), .fwd_wr(fwd_wr), .rd_q(rd_q),
  .rd_valid(rd_valid), .rd_data(rd_data),
  .fwd_len(fwd_len), .sec_bus(sec_bus_q)
);

// File: tb/test_cfg_router.sv
`timescale 1ns/1ps
module test_cfg_router;
  localparam int NPF = 32;
  localparam int NSF = 16;
  localparam logic [15:0] VEN = 16'hABCD;
  localparam logic [15:0] DEV = 16'h0042;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  cfg_len = 3'd4;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [NPF*32-1:0] pri_rdata;
  logic [NSF*32-1:0] sec_rdata;
  logic [NPF-1:0] pri_sel;
  logic [NSF-1:0] sec_sel;
  logic [7:0]  fwd_off;
  logic [31:0] fwd_wdata;
  logic [2:0]  fwd_len;
  logic        fwd_wr, fwd_rd, rd_valid;
  logic [31:0] rd_data;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] sec_m = 8'h00;

  logic [NPF-1:0] s_pri;
  logic [NSF-1:0] s_sec;
  logic s_fwr, s_frd, s_valid;
  logic [7:0] s_off;
  logic [31:0] s_wd, s_rd;
  logic [2:0] s_len;

  always #10 clk = ~clk;

  for (genvar i = 0; i < NPF; i++) begin : g_pri
    assign pri_rdata[i*32 +: 32] = {8'(i), 8'h5A, 8'h00, fwd_off};
  end
  for (genvar j = 0; j < NSF; j++) begin : g_sec
    assign sec_rdata[j*32 +: 32] = {8'(j), 8'hC3, 8'h00, fwd_off};
  end

  cfg_router i_cfg_router (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_len(cfg_len), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .pri_rdata(pri_rdata), .sec_rdata(sec_rdata),
    .pri_sel(pri_sel), .sec_sel(sec_sel), .fwd_off(fwd_off),
    .fwd_wdata(fwd_wdata), .fwd_len(fwd_len), .fwd_wr(fwd_wr),
    .fwd_rd(fwd_rd), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input logic [2:0] len);
    return (len == 3'd1) ? 32'hFF : (len == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // 0 miss, 1 primary, 2 secondary, 3 bridge
  function automatic int exp_tgt(input logic [7:0] bus, input logic [7:0] devfn);
    int d;
    d = int'(devfn) / 8;
    if (bus == 8'h00) begin
      if (devfn == 8'h18) return 3;
      return (d == 0 || d == 2) ? 1 : 0;
    end
    if (sec_m != 8'h00 && bus == sec_m) return (d == 0) ? 2 : 0;
    return 0;
  endfunction

  function automatic logic [31:0] brg_read(input logic [7:0] off, input logic [2:0] len);
    logic [31:0] dw;
    case (int'(off) / 4)
      0: dw = {DEV, VEN};
      1: dw = 32'h00A0_0006;
      2: dw = 32'h0604_0000;
      3: dw = 32'h0081_1000;
      6: dw = {16'h0, sec_m, 8'h00};
      7: dw = 32'h00A0_0000;
      default: dw = 32'h0;
    endcase
    return (dw >> (8 * (int'(off) % 4))) & mask_of(len);
  endfunction

  task automatic access(input logic wr, input logic [7:0] bus, input logic [7:0] devfn,
                        input logic [7:0] off, input logic [2:0] len, input logic [31:0] wd);
    @(negedge clk);
    cfg_addr = {bus, devfn, off}; cfg_wdata = wd; cfg_len = len;
    cfg_wr = wr; cfg_rd = !wr;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_rd = 1'b0;
    s_pri = pri_sel; s_sec = sec_sel; s_fwr = fwd_wr; s_frd = fwd_rd;
    s_off = fwd_off; s_wd = fwd_wdata; s_len = fwd_len;
    @(negedge clk);
    s_valid = rd_valid; s_rd = rd_data;
  endtask

  function automatic string req_of(input int t);
    return (t == 1) ? "R2" : (t == 2) ? "R3" : (t == 3) ? "R6" : "R4";
  endfunction

  task automatic do_read(input logic [7:0] bus, input logic [7:0] devfn,
                         input logic [7:0] off, input logic [2:0] len);
    int t;
    logic [31:0] ed;
    t = exp_tgt(bus, devfn);
    access(1'b0, bus, devfn, off, len, 32'h0);
    case (t)
      1: ed = {devfn, 8'h5A, 8'h00, off} & mask_of(len);
      2: ed = {devfn, 8'hC3, 8'h00, off} & mask_of(len);
      3: ed = brg_read(off, len);
      default: ed = mask_of(len);
    endcase
    chk(req_of(t), "pri_sel", 64'(s_pri), (t == 1) ? 64'(1) << devfn : 64'h0);
    chk(req_of(t), "sec_sel", 64'(s_sec), (t == 2) ? 64'(1) << devfn : 64'h0);
    chk(req_of(t), "fwd_rd", 64'(s_frd), 64'(t == 1 || t == 2));
    chk("R5", "rd_valid", 64'(s_valid), 64'h1);
    chk(req_of(t), "rd_data", 64'(s_rd), 64'(ed));
    if (t == 1 || t == 2) begin
      chk("R1", "fwd_off", 64'(s_off), 64'(off));
      chk("R1", "fwd_len", 64'(s_len), 64'(len));
    end
  endtask

  task automatic do_write(input logic [7:0] bus, input logic [7:0] devfn,
                          input logic [7:0] off, input logic [2:0] len, input logic [31:0] wd);
    int t;
    t = exp_tgt(bus, devfn);
    access(1'b1, bus, devfn, off, len, wd);
    if (t == 3) begin
      if (off == 8'h19) sec_m = wd[7:0];
      else if (off == 8'h18 && len != 3'd1) sec_m = wd[15:8];
    end
    chk(req_of(t), "wr pri_sel", 64'(s_pri), (t == 1) ? 64'(1) << devfn : 64'h0);
    chk(req_of(t), "wr sec_sel", 64'(s_sec), (t == 2) ? 64'(1) << devfn : 64'h0);
    chk(req_of(t), "fwd_wr", 64'(s_fwr), 64'(t == 1 || t == 2));
    chk("R5", "no rd_valid after write", 64'(s_valid), 64'h0);
    if (t == 1 || t == 2) chk("R1", "fwd_wdata", 64'(s_wd), 64'(wd));
  endtask

  task automatic check_busnum();
    do_read(8'h00, 8'h18, 8'h19, 3'd1);
    chk("R7", "secondary bus number", 64'(s_rd), 64'(sec_m));
  endtask

  task automatic sweep(input logic [7:0] bus);
    for (int d = 0; d < 64; d++)
      do_read(bus, 8'(d), 8'((d * 4 + 8) & 8'hFC), 3'd4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8", "pri_sel after reset", 64'(pri_sel), 64'h0);
    chk("R8", "sec_sel after reset", 64'(sec_sel), 64'h0);
    chk("R8", "fwd_wr/fwd_rd after reset", 64'({fwd_wr, fwd_rd}), 64'h0);
    chk("R8", "rd_valid after reset", 64'(rd_valid), 64'h0);
    do_read(8'h00, 8'h18, 8'h19, 3'd1);
    chk("R8", "secondary bus after reset", 64'(s_rd), 64'h0);

    sweep(8'h00);
    sweep(8'h01);
    sweep(8'h00 + 8'h00);

    do_read(8'h00, 8'h18, 8'h00, 3'd4);
    do_read(8'h00, 8'h18, 8'h04, 3'd4);
    do_read(8'h00, 8'h18, 8'h08, 3'd4);
    do_read(8'h00, 8'h18, 8'h0C, 3'd4);
    do_read(8'h00, 8'h18, 8'h1C, 3'd4);
    do_read(8'h00, 8'h18, 8'h40, 3'd4);
    do_read(8'h00, 8'h18, 8'h0E, 3'd1);
    do_read(8'h00, 8'h18, 8'h0A, 3'd2);
    do_read(8'h00, 8'h18, 8'h0D, 3'd1);
    do_read(8'h00, 8'h18, 8'h1E, 3'd1);

    for (int l = 1; l <= 4; l++) begin
      do_read(8'h00, 8'h11, 8'h3C, 3'(l));
      do_read(8'h09, 8'h00, 8'h00, 3'(l));
      do_read(8'h00, 8'h18, 8'h02, 3'(l));
    end

    do_write(8'h00, 8'h18, 8'h19, 3'd1, 32'hFFFF_FF07);
    check_busnum();
    sweep(8'h07);
    sweep(8'h01);

    do_write(8'h00, 8'h18, 8'h18, 3'd2, 32'h0000_0305);
    check_busnum();
    do_write(8'h00, 8'h18, 8'h18, 3'd1, 32'h0000_0909);
    check_busnum();
    do_read(8'h07, 8'h00, 8'h10, 3'd4);
    do_read(8'h03, 8'h02, 8'h10, 3'd4);
    do_write(8'h00, 8'h18, 8'h18, 3'd4, 32'h1234_0C99);
    check_busnum();
    do_write(8'h00, 8'h18, 8'h04, 3'd4, 32'hFFFF_FFFF);
    do_read(8'h00, 8'h18, 8'h04, 3'd4);
    chk("R7", "ignored bridge write", 64'(s_rd), 64'h00A0_0006);
    do_write(8'h00, 8'h18, 8'h1A, 3'd1, 32'h0000_0055);
    check_busnum();
    sweep(8'h0C);
    do_read(8'h03, 8'h01, 8'h10, 3'd4);

    do_write(8'h00, 8'h10, 8'h3C, 3'd1, 32'h0000_00A5);
    do_write(8'h00, 8'h07, 8'h20, 3'd4, 32'hDEAD_BEEF);
    do_write(8'h0C, 8'h03, 8'h10, 3'd4, 32'h1357_9BDF);
    do_write(8'h0C, 8'h09, 8'h10, 3'd4, 32'h2468_ACE0);
    do_write(8'h05, 8'h00, 8'h10, 3'd4, 32'h0F0F_0F0F);
    do_write(8'h00, 8'h08, 8'h10, 3'd2, 32'h0000_1111);
    do_write(8'h00, 8'h1B, 8'h10, 3'd4, 32'h0000_2222);

    do_write(8'h00, 8'h18, 8'h19, 3'd1, 32'h0000_0000);
    check_busnum();
    do_read(8'h0C, 8'h00, 8'h00, 3'd4);
    do_read(8'h00, 8'h00, 8'h00, 3'd4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule